// File: doc/BRIEF.md
# Configuration Access Port Router

This block gives software a small register window into configuration space for a root-style PCI Express controller. Software first writes a target address register. That register names a bus, a device, a function and a dword register number, and it carries an enable bit. A later read or write of the data window starts one configuration cycle at that target. A third window returns the link-trained flag, so software can check link training before it reaches outward.

Each data-window access goes to one of two places. When the target is the controller's own header (its primary bus, its own device number, function zero), the access uses a local dword register file. Otherwise the block builds a Type 0 or Type 1 request descriptor and places it on a valid/ready request channel. It then stalls until a completion returns. The primary, secondary and subordinate bus numbers that steer this choice are read from dword 6 of the controller's own bridge header. Software therefore sets up the routing with ordinary internal configuration writes.

Top module: `cfg_port_router`

## Requirements
- R1: The address register keeps only bit 31 (enable), bits 23:16 (bus), 15:11 (device), 10:8 (function) and 7:2 (register number). Every other bit reads back as zero through window select 0.
- R2: A strobe to window select 0 (address) or 2 (link status) issues no external request. It raises reg_done exactly one cycle after the strobe.
- R3: A data access (select 1) with enable set, target bus equal to the primary bus, device equal to OWN_DEV and function 0 uses the local register file. It completes one cycle after the strobe. If the function is nonzero or the device differs, the local file is not reached.
- R4: In the local dword 6, bits 7:0 give the primary bus, bits 15:8 the secondary bus and bits 23:16 the subordinate bus. A write to dword 6 changes the routing of every later access.
- R5: An external access whose bus equals the secondary bus is issued as Type 0 (ext_req_type1=0). A bus above the secondary bus and no higher than the subordinate bus is issued as Type 1. The descriptor carries the bus, device, function and register number. A read carries data 0 and byte enables 4'hF.
- R6: A data access with the enable bit clear, or with a bus outside every route, completes one cycle after the strobe. It issues no request, a read returns 32'hFFFFFFFF, and a write changes nothing.
- R7: An external-bound access made while link_up is low issues no request and reads all ones. The link_up value sampled in the strobe cycle decides this. Window select 2 returns link_up in bit 0 and zeros elsewhere.
- R8: An issued request holds ext_req_valid and its fields steady until ext_req_ready. reg_busy stays high from the cycle after the strobe until reg_done. reg_done rises one cycle after ext_cpl_valid and carries ext_cpl_data.
- R9: A completion that has ext_cpl_ur set returns 32'hFFFFFFFF whatever its data.
- R10: Byte lane k is data bits 8k+7:8k and maps to configuration byte 4*reg+k. An external write passes reg_be and reg_wdata unchanged. A local write updates only the lanes whose enable is set.
- R11: A local access to a register number at or beyond NUM_DW reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_stb | input | 1 | One-cycle window access strobe |
| reg_we | input | 1 | Strobe is a write |
| reg_sel | input | 2 | Window: 0 address, 1 data, 2 link status |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Write byte enables, lane k = bits 8k+7:8k |
| reg_busy | output | 1 | External cycle outstanding; software waits |
| reg_done | output | 1 | One-cycle completion pulse |
| reg_rdata | output | 32 | Read data, valid with reg_done |
| link_up | input | 1 | Link training has completed |
| ext_req_valid | output | 1 | External request descriptor valid |
| ext_req_ready | input | 1 | Request accepted |
| ext_req_type1 | output | 1 | 1 = Type 1, 0 = Type 0 |
| ext_req_write | output | 1 | 1 = configuration write |
| ext_req_bus | output | 8 | Target bus |
| ext_req_dev | output | 5 | Target device |
| ext_req_func | output | 3 | Target function |
| ext_req_regn | output | 6 | Target dword register number |
| ext_req_data | output | 32 | Write data |
| ext_req_be | output | 4 | Byte enables |
| ext_cpl_valid | input | 1 | Completion arrives |
| ext_cpl_ur | input | 1 | Completion has unsupported-request status |
| ext_cpl_data | input | 32 | Completion read data |

## Verification
The link_up flag can change in the same cycle that a data-window strobe is decoded. The bench drives link_up low and high on exactly the strobe edge. It expects the value sampled there to decide the access, with no request and all ones in one case and a full Type 0 round trip in the other. The bench also lets the acceptance of a request lag behind its issue, and it lets a completion follow acceptance with no gap. Each data word is then judged against the scoreboard entry pushed by the driver, and each descriptor against the expected request queued with it.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

    localparam int          WORD_W         = 32;
    localparam int          LANES          = WORD_W / 8;
    localparam int          BUSNUM_DWORD   = 6;
    localparam logic [31:0] ADDR_KEEP_MASK = 32'h80FF_FFFC;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_DATA = 2'd1,
        SEL_LINK = 2'd2,
        SEL_RSVD = 2'd3
    } port_sel_e;

    typedef enum logic [1:0] {
        RT_DROP,
        RT_LOCAL,
        RT_TYPE0,
        RT_TYPE1
    } route_e;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_REQ,
        ENG_WAIT
    } eng_state_e;

    typedef struct packed {
        logic       en;
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] func;
        logic [5:0] regn;
    } cfg_target_t;

    typedef struct packed {
        logic [7:0] prim;
        logic [7:0] sec;
        logic [7:0] sub;
    } bus_range_t;

    typedef struct packed {
        logic              type1;
        logic              write;
        logic [7:0]        bus;
        logic [4:0]        dev;
        logic [2:0]        func;
        logic [5:0]        regn;
        logic [WORD_W-1:0] data;
        logic [LANES-1:0]  be;
    } ext_desc_t;

    function automatic logic [WORD_W-1:0] merge_lanes(
        input logic [WORD_W-1:0] old_v,
        input logic [WORD_W-1:0] new_v,
        input logic [LANES-1:0]  be
    );
        logic [WORD_W-1:0] r;
        r = old_v;
        for (int k = 0; k < LANES; k++) begin
            if (be[k]) r[8*k +: 8] = new_v[8*k +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/cfg_route_decode.sv
module cfg_route_decode
    import cfg_port_pkg::*;
#(
    parameter int OWN_DEV = 0
) (
    input  logic       en,
    input  logic [7:0] bus,
    input  logic [4:0] dev,
    input  logic [2:0] func,
    input  bus_range_t buses,
    input  logic       link_up,
    output route_e     route
);
    localparam logic [4:0] OWN_DEV_NUM = 5'(OWN_DEV);

    logic own_hit;
    assign own_hit = (bus == buses.prim) && (dev == OWN_DEV_NUM) && (func == 3'd0);

    always_comb begin
        route = RT_DROP;
        if (!en)                                  route = RT_DROP;
        else if (own_hit)                         route = RT_LOCAL;
        else if (!link_up)                        route = RT_DROP;
        else if (bus == buses.sec)                route = RT_TYPE0;
        else if (bus > buses.sec && bus <= buses.sub) route = RT_TYPE1;
    end
endmodule

// File: rtl/cfg_local_regs.sv
module cfg_local_regs
    import cfg_port_pkg::*;
#(
    parameter int NUM_DW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [5:0]        idx,
    input  logic [WORD_W-1:0] wdata,
    input  logic [LANES-1:0]  be,
    output logic [WORD_W-1:0] rdata,
    output bus_range_t        buses
);
    localparam int IDX_W = (NUM_DW > 1) ? $clog2(NUM_DW) : 1;

    logic [WORD_W-1:0] mem [NUM_DW];
    logic              in_range;

    assign in_range = (int'(idx) < NUM_DW);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_DW; i++) mem[i] <= '0;
        end else if (wr_en && in_range) begin
            mem[idx[IDX_W-1:0]] <= merge_lanes(mem[idx[IDX_W-1:0]], wdata, be);
        end
    end

    assign rdata       = in_range ? mem[idx[IDX_W-1:0]] : '0;
    assign buses.prim  = mem[BUSNUM_DWORD][7:0];
    assign buses.sec   = mem[BUSNUM_DWORD][15:8];
    assign buses.sub   = mem[BUSNUM_DWORD][23:16];
endmodule

// File: rtl/cfg_ext_engine.sv
module cfg_ext_engine
    import cfg_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  ext_desc_t         desc_in,
    output logic              req_valid,
    output ext_desc_t         desc_out,
    input  logic              req_ready,
    input  logic              cpl_valid,
    input  logic              cpl_ur,
    input  logic [WORD_W-1:0] cpl_data,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rdata
);
    eng_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ENG_IDLE;
            desc_out <= '0;
            done     <= 1'b0;
            rdata    <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ENG_IDLE: if (start) begin
                    desc_out <= desc_in;
                    state    <= ENG_REQ;
                end
                ENG_REQ: if (req_ready) state <= ENG_WAIT;
                ENG_WAIT: if (cpl_valid) begin
                    done  <= 1'b1;
                    rdata <= cpl_ur ? '1 : cpl_data;
                    state <= ENG_IDLE;
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    assign req_valid = (state == ENG_REQ);
    assign busy      = (state != ENG_IDLE);

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(desc_out));

    // R8
    cpl_done_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ENG_WAIT) && cpl_valid |=> done && !busy);

    // R9
    ur_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ENG_WAIT) && cpl_valid && cpl_ur |=> rdata == '1);
endmodule

// File: rtl/cfg_port_router.sv
module cfg_port_router
    import cfg_port_pkg::*;
#(
    parameter int NUM_DW  = 16,
    parameter int OWN_DEV = 0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_stb,
    input  logic        reg_we,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    input  logic [3:0]  reg_be,
    output logic        reg_busy,
    output logic        reg_done,
    output logic [31:0] reg_rdata,
    input  logic        link_up,
    output logic        ext_req_valid,
    input  logic        ext_req_ready,
    output logic        ext_req_type1,
    output logic        ext_req_write,
    output logic [7:0]  ext_req_bus,
    output logic [4:0]  ext_req_dev,
    output logic [2:0]  ext_req_func,
    output logic [5:0]  ext_req_regn,
    output logic [31:0] ext_req_data,
    output logic [3:0]  ext_req_be,
    input  logic        ext_cpl_valid,
    input  logic        ext_cpl_ur,
    input  logic [31:0] ext_cpl_data
);
    logic [WORD_W-1:0] addr_q;
    cfg_target_t       tgt;
    bus_range_t        buses;
    route_e            route;
    port_sel_e         sel;
    logic              stb_ok, is_data, loc_wr, eng_start;
    logic              eng_busy, eng_done;
    logic [WORD_W-1:0] eng_rdata, loc_rd;
    logic              loc_done_q;
    logic [WORD_W-1:0] loc_rdata_q;
    ext_desc_t         new_desc, cur_desc;

    assign tgt.en   = addr_q[31];
    assign tgt.bus  = addr_q[23:16];
    assign tgt.dev  = addr_q[15:11];
    assign tgt.func = addr_q[10:8];
    assign tgt.regn = addr_q[7:2];

    assign sel     = port_sel_e'(reg_sel);
    assign stb_ok  = reg_stb && !eng_busy;
    assign is_data = stb_ok && (sel == SEL_DATA);
    assign loc_wr  = is_data && reg_we && (route == RT_LOCAL);
    assign eng_start = is_data && (route == RT_TYPE0 || route == RT_TYPE1);

    cfg_route_decode #(.OWN_DEV(OWN_DEV)) u_decode (
        .en(tgt.en), .bus(tgt.bus), .dev(tgt.dev), .func(tgt.func),
        .buses(buses), .link_up(link_up), .route(route)
    );

    cfg_local_regs #(.NUM_DW(NUM_DW)) u_local (
        .clk(clk), .rst(rst), .wr_en(loc_wr), .idx(tgt.regn),
        .wdata(reg_wdata), .be(reg_be), .rdata(loc_rd), .buses(buses)
    );

    always_comb begin
        new_desc.type1 = (route == RT_TYPE1);
        new_desc.write = reg_we;
        new_desc.bus   = tgt.bus;
        new_desc.dev   = tgt.dev;
        new_desc.func  = tgt.func;
        new_desc.regn  = tgt.regn;
        new_desc.data  = reg_we ? reg_wdata : '0;
        new_desc.be    = reg_we ? reg_be : '1;
    end

    cfg_ext_engine u_engine (
        .clk(clk), .rst(rst), .start(eng_start), .desc_in(new_desc),
        .req_valid(ext_req_valid), .desc_out(cur_desc), .req_ready(ext_req_ready),
        .cpl_valid(ext_cpl_valid), .cpl_ur(ext_cpl_ur), .cpl_data(ext_cpl_data),
        .busy(eng_busy), .done(eng_done), .rdata(eng_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q      <= '0;
            loc_done_q  <= 1'b0;
            loc_rdata_q <= '0;
        end else begin
            loc_done_q <= 1'b0;
            if (stb_ok) begin
                case (sel)
                    SEL_ADDR: begin
                        if (reg_we) addr_q <= reg_wdata & ADDR_KEEP_MASK;
                        loc_done_q  <= 1'b1;
                        loc_rdata_q <= reg_we ? '0 : addr_q;
                    end
                    SEL_LINK: begin
                        loc_done_q  <= 1'b1;
                        loc_rdata_q <= reg_we ? '0 : {{(WORD_W-1){1'b0}}, link_up};
                    end
                    SEL_DATA: begin
                        if (route == RT_LOCAL) begin
                            loc_done_q  <= 1'b1;
                            loc_rdata_q <= reg_we ? '0 : loc_rd;
                        end else if (route == RT_DROP) begin
                            loc_done_q  <= 1'b1;
                            loc_rdata_q <= reg_we ? '0 : '1;
                        end
                    end
                    default: begin
                        loc_done_q  <= 1'b1;
                        loc_rdata_q <= '1;
                    end
                endcase
            end
        end
    end

    assign reg_busy      = eng_busy;
    assign reg_done      = loc_done_q | eng_done;
    assign reg_rdata     = eng_done ? eng_rdata : loc_rdata_q;
    assign ext_req_type1 = cur_desc.type1;
    assign ext_req_write = cur_desc.write;
    assign ext_req_bus   = cur_desc.bus;
    assign ext_req_dev   = cur_desc.dev;
    assign ext_req_func  = cur_desc.func;
    assign ext_req_regn  = cur_desc.regn;
    assign ext_req_data  = cur_desc.data;
    assign ext_req_be    = cur_desc.be;

    // R5
    ext_route_chk: assert property (@(posedge clk) disable iff (rst)
        ext_req_valid |-> (ext_req_bus >= buses.sec) && (ext_req_bus <= buses.sub)
                          && (ext_req_type1 == (ext_req_bus != buses.sec)));

    // R7
    link_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ext_req_valid) |-> $past(link_up));

    // R2
    no_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        reg_stb && !reg_busy && (reg_sel != 2'd1) |=> reg_done && !ext_req_valid);

    // R6
    drop_fast_chk: assert property (@(posedge clk) disable iff (rst)
        reg_stb && !reg_busy && (reg_sel == 2'd1) && !addr_q[31] |=> reg_done && !reg_busy);
endmodule

// File: tb/cfg_port_router_bench.sv
module cfg_port_router_bench;
    import cfg_port_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_stb = 0, reg_we = 0;
    logic [1:0]  reg_sel = 0;
    logic [31:0] reg_wdata = 0;
    logic [3:0]  reg_be = 0;
    logic        reg_busy, reg_done;
    logic [31:0] reg_rdata;
    logic        link_up = 0;
    logic        ext_req_valid, ext_req_ready = 0;
    logic        ext_req_type1, ext_req_write;
    logic [7:0]  ext_req_bus;
    logic [4:0]  ext_req_dev;
    logic [2:0]  ext_req_func;
    logic [5:0]  ext_req_regn;
    logic [31:0] ext_req_data;
    logic [3:0]  ext_req_be;
    logic        ext_cpl_valid = 0, ext_cpl_ur = 0;
    logic [31:0] ext_cpl_data = 0;

    int n_cmp = 0, n_bad = 0, done_seen = 0;
    logic        link_cmd = 0;
    int          rsp_rdy_wait = 0, rsp_cpl_wait = 0;
    logic        rsp_ur = 0;
    logic [31:0] rsp_data = 0;

    logic [32:0] exp_q[$];
    string       tag_q[$];
    ext_desc_t   req_q[$];
    string       rtag_q[$];

    always #4 clk = ~clk;

    cfg_port_router u_cfg_port_router (
        .clk(clk), .rst(rst), .reg_stb(reg_stb), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_busy(reg_busy), .reg_done(reg_done),
        .reg_rdata(reg_rdata), .link_up(link_up), .ext_req_valid(ext_req_valid),
        .ext_req_ready(ext_req_ready), .ext_req_type1(ext_req_type1),
        .ext_req_write(ext_req_write), .ext_req_bus(ext_req_bus), .ext_req_dev(ext_req_dev),
        .ext_req_func(ext_req_func), .ext_req_regn(ext_req_regn), .ext_req_data(ext_req_data),
        .ext_req_be(ext_req_be), .ext_cpl_valid(ext_cpl_valid), .ext_cpl_ur(ext_cpl_ur),
        .ext_cpl_data(ext_cpl_data)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp,
                         input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic en, input logic [7:0] bus,
                                       input logic [4:0] dev, input logic [2:0] fn,
                                       input logic [5:0] rn);
        return {en, 7'b0, bus, dev, fn, rn, 2'b00};
    endfunction

    // Monitor: pops the scoreboard as completions appear
    always @(negedge clk) begin
        if (!rst && reg_done) begin
            if (exp_q.size() == 0) begin
                check("R2", 64'(reg_rdata), 64'hDEAD, "unexpected reg_done");
            end else begin
                logic [32:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (e[32]) check(t, 64'(reg_rdata), 64'(e[31:0]), "read data");
            end
            done_seen++;
        end
    end

    // Responder: compares each descriptor and answers it
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && ext_req_valid) begin
                ext_desc_t a;
                a = '{type1: ext_req_type1, write: ext_req_write, bus: ext_req_bus,
                      dev: ext_req_dev, func: ext_req_func, regn: ext_req_regn,
                      data: ext_req_data, be: ext_req_be};
                if (req_q.size() == 0) begin
                    check("R6", 64'(a), 64'h0, "unexpected external request");
                end else begin
                    string t;
                    t = rtag_q.pop_front();
                    check(t, 64'(a), 64'(req_q.pop_front()), "request descriptor");
                end
                for (int i = 0; i < rsp_rdy_wait; i++) begin
                    @(negedge clk);
                    check("R8", 64'(ext_req_valid), 64'd1, "valid held before ready");
                end
                ext_req_ready = 1'b1;
                @(negedge clk);
                ext_req_ready = 1'b0;
                for (int i = 0; i < rsp_cpl_wait; i++) @(negedge clk);
                ext_cpl_valid = 1'b1;
                ext_cpl_ur    = rsp_ur;
                ext_cpl_data  = rsp_data;
                @(negedge clk);
                ext_cpl_valid = 1'b0;
                ext_cpl_ur    = 1'b0;
            end
        end
    end

    task automatic access(input logic [1:0] sel, input logic we, input logic [31:0] wd,
                          input logic [3:0] be, input logic chk, input logic [31:0] exp,
                          input string tag, input logic expect_busy);
        int target;
        exp_q.push_back({chk, exp});
        tag_q.push_back(tag);
        target = done_seen + 1;
        @(negedge clk);
        reg_stb = 1; reg_we = we; reg_sel = sel; reg_wdata = wd; reg_be = be;
        link_up = link_cmd;
        @(negedge clk);
        reg_stb = 0; reg_we = 0;
        if (expect_busy) check("R8", 64'(reg_busy), 64'd1, "busy after strobe");
        while (done_seen < target) @(negedge clk);
    endtask

    task automatic expect_req(input logic t1, input logic wr, input logic [7:0] bus,
                              input logic [4:0] dev, input logic [2:0] fn, input logic [5:0] rn,
                              input logic [31:0] d, input logic [3:0] be, input string tag);
        req_q.push_back('{type1: t1, write: wr, bus: bus, dev: dev, func: fn, regn: rn,
                          data: d, be: be});
        rtag_q.push_back(tag);
    endtask

    task automatic set_addr(input logic [31:0] a);
        access(2'd0, 1, a, 4'hF, 0, 0, "R2", 0);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        check("R8", 64'd0, 64'd1, "watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R8", 64'(reg_busy), 64'd0, "reset busy");
        check("R2", 64'(reg_done), 64'd0, "reset done");
        check("R5", 64'(ext_req_valid), 64'd0, "reset request valid");
        access(2'd0, 0, 0, 4'hF, 1, 32'h0, "R1", 0);
        access(2'd2, 0, 0, 4'hF, 1, 32'h0, "R7", 0);

        // header bus numbers: prim 10, sec 11, sub 14
        set_addr(mk(1, 8'h00, 0, 0, 6));
        access(2'd1, 1, 32'h0014_1110, 4'hF, 0, 0, "R4", 0);
        access(2'd1, 0, 0, 4'hF, 1, 32'hFFFF_FFFF, "R4", 0);
        set_addr(mk(1, 8'h10, 0, 0, 6));
        access(2'd1, 0, 0, 4'hF, 1, 32'h0014_1110, "R3", 0);

        set_addr(mk(1, 8'h10, 0, 0, 3));
        access(2'd1, 1, 32'hAABB_CCDD, 4'hF, 0, 0, "R10", 0);
        access(2'd1, 1, 32'h1122_3344, 4'b0101, 0, 0, "R10", 0);
        access(2'd1, 0, 0, 4'hF, 1, 32'hAA22_CC44, "R10", 0);

        set_addr(mk(1, 8'h10, 0, 1, 3));
        access(2'd1, 0, 0, 4'hF, 1, 32'hFFFF_FFFF, "R3", 0);
        set_addr(mk(1, 8'h10, 1, 0, 3));
        access(2'd1, 0, 0, 4'hF, 1, 32'hFFFF_FFFF, "R3", 0);
        set_addr(mk(1, 8'h10, 0, 0, 6'h20));
        access(2'd1, 0, 0, 4'hF, 1, 32'h0, "R11", 0);

        set_addr(mk(1, 8'h11, 3, 2, 6'h0A));
        access(2'd1, 0, 0, 4'hF, 1, 32'hFFFF_FFFF, "R7", 0);
        link_cmd = 1;
        access(2'd2, 0, 0, 4'hF, 1, 32'h1, "R7", 0);

        rsp_rdy_wait = 3; rsp_cpl_wait = 2; rsp_data = 32'h1234_5678;
        expect_req(0, 0, 8'h11, 3, 2, 6'h0A, 0, 4'hF, "R5");
        access(2'd1, 0, 0, 4'hF, 1, 32'h1234_5678, "R5", 1);

        rsp_rdy_wait = 0; rsp_cpl_wait = 0; rsp_data = 32'hCAFE_F00D;
        set_addr(mk(1, 8'h13, 5'h1F, 7, 6'h3F));
        expect_req(1, 0, 8'h13, 5'h1F, 7, 6'h3F, 0, 4'hF, "R5");
        access(2'd1, 0, 0, 4'hF, 1, 32'hCAFE_F00D, "R5", 1);

        set_addr(mk(1, 8'h14, 2, 0, 1));
        expect_req(1, 1, 8'h14, 2, 0, 1, 32'h5566_7788, 4'b0011, "R10");
        access(2'd1, 1, 32'h5566_7788, 4'b0011, 0, 0, "R10", 1);

        rsp_ur = 1; rsp_data = 32'h0BAD_BEEF; rsp_cpl_wait = 1;
        set_addr(mk(1, 8'h11, 0, 0, 0));
        expect_req(0, 0, 8'h11, 0, 0, 0, 0, 4'hF, "R9");
        access(2'd1, 0, 0, 4'hF, 1, 32'hFFFF_FFFF, "R9", 1);
        rsp_ur = 0;

        set_addr(mk(1, 8'h15, 0, 0, 0));
        access(2'd1, 0, 0, 4'hF, 1, 32'hFFFF_FFFF, "R6", 0);
        set_addr(mk(1, 8'h0F, 0, 0, 0));
        access(2'd1, 0, 0, 4'hF, 1, 32'hFFFF_FFFF, "R6", 0);
        set_addr(mk(0, 8'h11, 0, 0, 0));
        access(2'd1, 0, 0, 4'hF, 1, 32'hFFFF_FFFF, "R6", 0);
        set_addr(mk(0, 8'h10, 0, 0, 3));
        access(2'd1, 1, 32'hDEAD_0000, 4'hF, 0, 0, "R6", 0);
        set_addr(mk(1, 8'h10, 0, 0, 3));
        access(2'd1, 0, 0, 4'hF, 1, 32'hAA22_CC44, "R6", 0);

        // link changes in the strobe cycle itself
        set_addr(mk(1, 8'h11, 4, 1, 2));
        link_cmd = 0;
        access(2'd1, 0, 0, 4'hF, 1, 32'hFFFF_FFFF, "R7", 0);
        link_cmd = 1; rsp_data = 32'h0F0F_A5A5;
        expect_req(0, 0, 8'h11, 4, 1, 2, 0, 4'hF, "R7");
        access(2'd1, 0, 0, 4'hF, 1, 32'h0F0F_A5A5, "R7", 1);

        access(2'd0, 1, 32'hFFFF_FFFF, 4'hF, 0, 0, "R1", 0);
        access(2'd0, 0, 0, 4'hF, 1, 32'h80FF_FFFC, "R1", 0);

        repeat (5) @(negedge clk);
        check("R5", 64'(req_q.size()), 64'd0, "expected requests left unissued");
        check("R2", 64'(exp_q.size()), 64'd0, "completions left outstanding");
        summary();
    end
endmodule